// File: doc/BRIEF.md
# Oscillator Frequency Trim Controller

This block keeps a free-running local oscillator close to its calibrated rate. It counts local-clock cycles across a span whose length is fixed by a slower, trusted timing source. It then compares that count with a programmed target and moves a 5-bit signed trim code one step in the correcting direction. The trim code drives the oscillator's analog tuning input. Code 0 is the calibrated centre, positive codes raise the frequency and negative codes lower it.

Two measurement sources are offered. In reference mode the span is a programmable number of rising edges of a reference clock. In event mode the span is the distance between two successive rising edges of an external event of known period, taken from a free-running counter. Both asynchronous inputs are brought into the local clock domain through two flops and a rising-edge detector.

Control is a four-state machine:
- `ST_IDLE` is entered whenever the enable is low.
- `ST_ARM` waits for the first edge of the selected source.
- `ST_WINDOW` counts over a reference span.
- `ST_SPAN` waits for the closing event edge.

Its transitions are:
- IDLE→ARM when enabled.
- ARM→WINDOW on a reference edge in reference mode.
- ARM→SPAN on an event edge in event mode.
- WINDOW→WINDOW on the closing reference edge if reference mode is still selected; that edge opens the next span.
- WINDOW→ARM on the closing edge if event mode is now selected.
- SPAN→SPAN on the closing event edge if event mode is still selected; that edge opens the next span.
- SPAN→ARM on the closing edge if reference mode is now selected.
- Any state→IDLE when the enable drops.

Top module: `osc_trim_ctrl`

## Requirements
- R1: After reset the trim code is 0, `done_o` is 0 and the `fast_o`, `slow_o` and `limit_o` flags are 0.
- R2: The trim code is 5-bit two's complement (5'b01111 = +15 is the highest frequency, 5'b10000 = -16 the lowest). When a completed measurement M exceeds `expect_i + tol_i`, the code decrements by exactly one and `fast_o` sets and stays set.
- R3: When `M + tol_i < expect_i`, the code increments by exactly one and `slow_o` sets and stays set.
- R4: When M lies within `tol_i` of `expect_i` (bounds inclusive), the code is unchanged and no flag sets.
- R5: The code saturates: it never goes from +15 to -16 or from -16 to +15. A step request that finds the code already at the limit in its direction leaves the code unchanged and sets `limit_o`, which then stays set.
- R6: In reference mode (`mode_i` = 0), M is the number of local cycles from the reference rising edge that opens a span to the `win_edges_i`-th reference rising edge after it. A value of 0 acts as 1. The closing edge also opens the next span. `done_o` pulses for one cycle per completed span, and the updated trim code is visible in that same cycle.
- R7: In event mode (`mode_i` = 1), M is the number of local cycles between two successive event rising edges, taken modulo 2^CNT_W. It is therefore correct across a wrap of the free-running counter. Each event edge closes one span and opens the next.
- R8: `mode_i` and `win_edges_i` are taken only when a span opens. A change made during a span affects the next span.
- R9: While `enable_i` is low the block is idle, `done_o` stays low, the three flags are cleared and the trim code holds. After re-enable no adjustment happens until a full span has completed.
- R10: The reference and event inputs pass through a two-flop synchronizer. Each rising edge produces exactly one single-cycle pulse in the local domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local oscillator clock being trimmed |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | 1 | Reference clock, asynchronous |
| event_i | input | 1 | External event of known period, asynchronous |
| enable_i | input | 1 | Run measurements and trimming |
| mode_i | input | 1 | 0 = reference-span mode, 1 = event-capture mode |
| win_edges_i | input | WIN_W | Reference rising edges per span |
| expect_i | input | CNT_W | Target local-cycle count per span |
| tol_i | input | CNT_W | Dead-band half-width in local cycles |
| trim_o | output | 5 | Signed trim code |
| done_o | output | 1 | One-cycle pulse per completed span |
| fast_o | output | 1 | Sticky: a span measured too fast |
| slow_o | output | 1 | Sticky: a span measured too slow |
| limit_o | output | 1 | Sticky: a step was blocked at a trim limit |

## Verification
The hardest situation to reach from the ports is an event-mode span that straddles the wrap of the 16-bit free-running counter. The counter cannot be read or preset. The bench therefore runs event mode continuously with a 3000-cycle event period for 25 spans, which covers more than 65536 cycles, so at least one span must cross the wrap. The target equals the true period and the dead band is tight. A wrong difference across the wrap would show up as a trim step or a set flag, and the bench checks that neither occurs. Trim saturation is reached the same way, by driving many consecutive spans whose measurement misses the target in one direction.

// File: rtl/trim_pkg.sv
package trim_pkg;
    localparam int TRIM_W = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_WINDOW,
        ST_SPAN
    } meas_state_e;

    typedef enum logic [1:0] {
        CMP_HOLD,
        CMP_FAST,
        CMP_SLOW
    } cmp_e;
endpackage

// File: rtl/trim_edge_sync.sv
module trim_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], async_i};
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

    // R10: a rising edge yields a single-cycle pulse
    a_r10_single_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);
endmodule

// File: rtl/trim_meas_fsm.sv
module trim_meas_fsm
    import trim_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int WIN_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic             mode_i,
    input  logic [WIN_W-1:0] win_edges_i,
    input  logic             ref_rise_i,
    input  logic             evt_rise_i,
    output logic             meas_valid_o,
    output logic [CNT_W-1:0] meas_o
);
    meas_state_e      state_q, state_d;
    logic [CNT_W-1:0] lcnt_q;
    logic [CNT_W-1:0] fcnt_q;
    logic [CNT_W-1:0] cap_q;
    logic [WIN_W-1:0] rcnt_q;
    logic [WIN_W-1:0] len_q;
    logic [WIN_W:0]   rcnt_next;
    logic             win_end;
    logic             span_end;
    logic             win_start;
    logic             span_start;

    assign rcnt_next  = {1'b0, rcnt_q} + 1'b1;
    assign win_end    = (state_q == ST_WINDOW) && ref_rise_i && (rcnt_next >= {1'b0, len_q});
    assign span_end   = (state_q == ST_SPAN) && evt_rise_i;
    assign win_start  = (state_d == ST_WINDOW) && ((state_q == ST_ARM) || win_end);
    assign span_start = (state_d == ST_SPAN) && ((state_q == ST_ARM) || span_end);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = ST_ARM;
            ST_ARM: begin
                if (mode_i ? evt_rise_i : ref_rise_i) begin
                    state_d = mode_i ? ST_SPAN : ST_WINDOW;
                end
            end
            ST_WINDOW: begin
                if (win_end) begin
                    state_d = mode_i ? ST_ARM : ST_WINDOW;
                end
            end
            ST_SPAN: begin
                if (span_end) begin
                    state_d = mode_i ? ST_SPAN : ST_ARM;
                end
            end
            default:   state_d = ST_IDLE;
        endcase
        if (!enable_i) begin
            state_d = ST_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // counters and span capture
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lcnt_q <= '0;
            fcnt_q <= '0;
            cap_q  <= '0;
            rcnt_q <= '0;
            len_q  <= '0;
        end else begin
            fcnt_q <= fcnt_q + 1'b1;
            if (win_start) begin
                lcnt_q <= CNT_W'(1);
                rcnt_q <= '0;
                len_q  <= win_edges_i;
            end else if (state_q == ST_WINDOW) begin
                lcnt_q <= lcnt_q + 1'b1;
                if (ref_rise_i) begin
                    rcnt_q <= rcnt_q + 1'b1;
                end
            end
            if (span_start) begin
                cap_q <= fcnt_q;
            end
        end
    end

    // outputs
    always_comb begin
        meas_valid_o = enable_i && (win_end || span_end);
        meas_o       = (state_q == ST_WINDOW) ? lcnt_q : (fcnt_q - cap_q);
    end

    // R8: span length is frozen while a reference span is open
    a_r8_len_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_WINDOW && $past(state_q) == ST_WINDOW && !$past(win_end))
        |-> $stable(len_q));

    // R6: a reference-mode result is only produced on a reference edge
    a_r6_end_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (meas_valid_o && state_q == ST_WINDOW) |-> ref_rise_i);
endmodule

// File: rtl/trim_step_unit.sv
module trim_step_unit
    import trim_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     enable_i,
    input  logic                     meas_valid_i,
    input  logic [CNT_W-1:0]         meas_i,
    input  logic [CNT_W-1:0]         expect_i,
    input  logic [CNT_W-1:0]         tol_i,
    output logic signed [TRIM_W-1:0] trim_o,
    output logic                     done_o,
    output logic                     fast_o,
    output logic                     slow_o,
    output logic                     limit_o
);
    localparam logic signed [TRIM_W-1:0] TRIM_MAX = TRIM_W'((1 << (TRIM_W - 1)) - 1);
    localparam logic signed [TRIM_W-1:0] TRIM_MIN = TRIM_W'(1 << (TRIM_W - 1));

    logic signed [TRIM_W-1:0] trim_q;
    logic [CNT_W:0]           upper;
    logic [CNT_W:0]           meas_plus_tol;
    cmp_e                     verdict;

    assign upper         = {1'b0, expect_i} + {1'b0, tol_i};
    assign meas_plus_tol = {1'b0, meas_i} + {1'b0, tol_i};

    always_comb begin
        if ({1'b0, meas_i} > upper) begin
            verdict = CMP_FAST;
        end else if (meas_plus_tol < {1'b0, expect_i}) begin
            verdict = CMP_SLOW;
        end else begin
            verdict = CMP_HOLD;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            trim_q  <= '0;
            done_o  <= 1'b0;
            fast_o  <= 1'b0;
            slow_o  <= 1'b0;
            limit_o <= 1'b0;
        end else begin
            done_o <= meas_valid_i;
            if (!enable_i) begin
                fast_o  <= 1'b0;
                slow_o  <= 1'b0;
                limit_o <= 1'b0;
            end else if (meas_valid_i) begin
                unique case (verdict)
                    CMP_FAST: begin
                        fast_o <= 1'b1;
                        if (trim_q == TRIM_MIN) limit_o <= 1'b1;
                        else                    trim_q  <= trim_q - 1'b1;
                    end
                    CMP_SLOW: begin
                        slow_o <= 1'b1;
                        if (trim_q == TRIM_MAX) limit_o <= 1'b1;
                        else                    trim_q  <= trim_q + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign trim_o = trim_q;

    // R2 / R3: at most one step per cycle
    a_r2_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trim_q == $past(trim_q)) || (trim_q == $past(trim_q) + 5'sd1)
        || (trim_q == $past(trim_q) - 5'sd1));
    // R5: no wrap from the top limit
    a_r5_no_wrap_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trim_q == TRIM_MAX) |=> (trim_q != TRIM_MIN));
    // R5: no wrap from the bottom limit
    a_r5_no_wrap_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trim_q == TRIM_MIN) |=> (trim_q != TRIM_MAX));
    // R6: the code only moves in a done cycle
    a_r6_move_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trim_q != $past(trim_q)) |-> done_o);
    // R6: done is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
endmodule

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl
    import trim_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int WIN_W     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ref_clk_i,
    input  logic             event_i,
    input  logic             enable_i,
    input  logic             mode_i,
    input  logic [WIN_W-1:0] win_edges_i,
    input  logic [CNT_W-1:0] expect_i,
    input  logic [CNT_W-1:0] tol_i,
    output logic [4:0]       trim_o,
    output logic             done_o,
    output logic             fast_o,
    output logic             slow_o,
    output logic             limit_o
);
    localparam int NUM_SRC = 2;

    logic [NUM_SRC-1:0]       async_in;
    logic [NUM_SRC-1:0]       rise;
    logic                     meas_valid;
    logic [CNT_W-1:0]         meas;
    logic signed [TRIM_W-1:0] trim_s;

    assign async_in = {event_i, ref_clk_i};

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
        trim_edge_sync #(
            .STAGES(SYNC_DEPTH)
        ) u_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .async_i(async_in[g]),
            .rise_o (rise[g])
        );
    end

    trim_meas_fsm #(
        .CNT_W(CNT_W),
        .WIN_W(WIN_W)
    ) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .enable_i    (enable_i),
        .mode_i      (mode_i),
        .win_edges_i (win_edges_i),
        .ref_rise_i  (rise[0]),
        .evt_rise_i  (rise[1]),
        .meas_valid_o(meas_valid),
        .meas_o      (meas)
    );

    trim_step_unit #(
        .CNT_W(CNT_W)
    ) u_step (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .enable_i    (enable_i),
        .meas_valid_i(meas_valid),
        .meas_i      (meas),
        .expect_i    (expect_i),
        .tol_i       (tol_i),
        .trim_o      (trim_s),
        .done_o      (done_o),
        .fast_o      (fast_o),
        .slow_o      (slow_o),
        .limit_o     (limit_o)
    );

    assign trim_o = trim_s;

    // R9: no completion pulse once the block has been disabled
    a_r9_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(enable_i) |-> !done_o);
    // R9: flags are clear one cycle after disable
    a_r9_flags_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(enable_i) |-> !(fast_o || slow_o || limit_o));
endmodule

// File: tb/osc_trim_ctrl_test.sv
`timescale 1ns/1ps
module osc_trim_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_clk = 1'b0;
    logic        evt = 1'b0;
    logic        enable = 1'b0;
    logic        mode = 1'b0;
    logic [7:0]  win_edges = 8'd4;
    logic [15:0] expect_cnt = 16'd0;
    logic [15:0] tol = 16'd0;
    logic [4:0]  trim;
    logic        done, fast, slow, limit;

    int checks = 0;
    int failures = 0;
    int ref_period = 8;
    int ref_ph = 0;
    int ev_period = 50;
    int ev_ph = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    osc_trim_ctrl uut (
        .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .event_i(evt),
        .enable_i(enable), .mode_i(mode), .win_edges_i(win_edges),
        .expect_i(expect_cnt), .tol_i(tol), .trim_o(trim), .done_o(done),
        .fast_o(fast), .slow_o(slow), .limit_o(limit)
    );

    // stimulus generators, advanced away from the active edge
    always @(negedge clk) begin
        ref_clk <= (ref_ph < ref_period / 2);
        ref_ph  <= (ref_ph >= ref_period - 1) ? 0 : ref_ph + 1;
        evt     <= (ev_ph < 5);
        ev_ph   <= (ev_ph >= ev_period - 1) ? 0 : ev_ph + 1;
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int strim();
        return int'($signed(trim));
    endfunction

    task automatic cycles(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_done(string req);
        int n = 0;
        do begin
            @(posedge clk);
            #1;
            n++;
        end while (!done && n < 20000);
        if (!done) check({req, " done timeout"}, 0, 1);
    endtask

    task automatic do_reset();
        enable = 1'b0;
        rst_n  = 1'b0;
        cycles(4);
        rst_n = 1'b1;
        cycles(2);
    endtask

    task automatic test_reset();
        do_reset();
        check("R1 trim", strim(), 0);
        check("R1 done", int'(done), 0);
        check("R1 flags", int'({fast, slow, limit}), 0);
    endtask

    task automatic test_fast_and_disable();
        do_reset();
        mode = 0; win_edges = 4; ref_period = 8;   // span = 32 cycles
        expect_cnt = 20; tol = 2;
        enable = 1;
        for (int k = 1; k <= 3; k++) begin
            wait_done("R2");
            check("R2 decrement", strim(), -k);
        end
        check("R2 fast flag", int'(fast), 1);
        check("R2 slow flag", int'(slow), 0);
        // R9: disable clears flags, holds code, no done
        enable = 0;
        cycles(2);
        check("R9 flags cleared", int'({fast, slow, limit}), 0);
        check("R9 trim held", strim(), -3);
        begin
            int seen = 0;
            for (int i = 0; i < 200; i++) begin
                cycles(1);
                if (done) seen++;
            end
            check("R9 no done while off", seen, 0);
        end
        // R9: first span after re-enable is complete (32 is in band, partial is not)
        expect_cnt = 30; tol = 2;
        cycles(3);
        enable = 1;
        wait_done("R9");
        check("R9 full span after re-enable", strim(), -3);
        check("R9 no flag after full span", int'({fast, slow}), 0);
    endtask

    task automatic test_dead_band();
        do_reset();
        mode = 0; win_edges = 4; ref_period = 8;
        expect_cnt = 30; tol = 2;                   // error 2 == tol
        enable = 1;
        wait_done("R4");
        wait_done("R4");
        check("R4 edge of band hold", strim(), 0);
        check("R4 no flags", int'({fast, slow}), 0);
        expect_cnt = 29;                            // error 3 > tol
        wait_done("R4");
        check("R4 outside band steps", strim(), -1);
        expect_cnt = 34;                            // error -2 == tol
        wait_done("R4");
        check("R4 low edge of band hold", strim(), -1);
    endtask

    task automatic test_saturate_up();
        do_reset();
        mode = 0; win_edges = 4; ref_period = 8;
        expect_cnt = 100; tol = 0;
        enable = 1;
        for (int k = 1; k <= 20; k++) begin
            wait_done("R5");
            check("R3/R5 increment saturating", strim(), (k < 15) ? k : 15);
            if (k == 15) check("R5 limit not yet", int'(limit), 0);
        end
        check("R3 slow flag", int'(slow), 1);
        check("R5 limit flag high", int'(limit), 1);
    endtask

    task automatic test_saturate_down();
        do_reset();
        mode = 0; win_edges = 4; ref_period = 8;
        expect_cnt = 5; tol = 0;
        enable = 1;
        for (int k = 1; k <= 20; k++) begin
            wait_done("R5");
            check("R5 decrement saturating", strim(), (k < 16) ? -k : -16);
        end
        check("R5 limit flag low side", int'(limit), 1);
        check("R5 low code encoding", int'(trim), 5'b10000);
    endtask

    task automatic test_length_change();
        do_reset();
        mode = 0; win_edges = 4; ref_period = 8;
        expect_cnt = 48; tol = 2;
        enable = 1;
        wait_done("R8");
        check("R6 span of 4 edges slow", strim(), 1);
        win_edges = 8;                              // next span already open
        wait_done("R8");
        check("R8 change waits for next span", strim(), 2);
        wait_done("R8");
        check("R8 new length applied (64 fast)", strim(), 1);
        // R6: a length of 0 acts as 1 (8 cycles)
        win_edges = 0; expect_cnt = 8; tol = 0;
        wait_done("R6");
        wait_done("R6");
        check("R6 zero length acts as one", strim(), 0);
    endtask

    task automatic test_capture();
        do_reset();
        mode = 1; ev_period = 50;
        expect_cnt = 60; tol = 3;
        enable = 1;
        for (int k = 1; k <= 3; k++) begin
            wait_done("R7");
            check("R7 event span slow", strim(), k);
        end
        check("R7 slow flag", int'(slow), 1);
    endtask

    task automatic test_capture_wrap();
        do_reset();
        mode = 1; ev_period = 3000;
        expect_cnt = 3000; tol = 1;
        enable = 1;
        for (int k = 0; k < 25; k++) wait_done("R7");
        check("R7 wrap-safe difference trim", strim(), 0);
        check("R7 wrap-safe difference flags", int'({fast, slow}), 0);
        enable = 0;
        ev_period = 50;
    endtask

    initial begin
        test_reset();
        test_fast_and_disable();
        test_dead_band();
        test_saturate_up();
        test_saturate_down();
        test_length_change();
        test_capture();
        test_capture_wrap();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=expired expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule